// File: doc/BRIEF.md
# Overflow Interrupt Aggregator

This block gathers one-cycle overflow pulses from counters and receive FIFOs. It holds each pulse in a sticky status bit that a host reads and clears through a small synchronous register port. There are three groups of sources.

- **Bonded groups.** Each group has a leaf register of four counter overflow bits and one receive-FIFO overflow bit. The leaf registers feed a per-group summary register. That summary is masked by a group enable register and by a FIFO-overflow enable register.
- **Per-link counters.** One register holds their overflows.
- **Non-bonded mode.** One register holds four transmit counter overflows and one receive-FIFO overflow.

All three groups drive a single registered interrupt line.

A host that sees the interrupt reads the summary first. This tells it which group is reporting, so it needs fewer accesses. It then reads that group's leaf register. It clears a bit by writing 0 to that bit position. Reads never clear anything. Writing 1 to a status bit leaves the bit unchanged.

Top module: `ovf_irq_aggregator`

## Requirements
- R1: A pulse on a group counter input `grp_cnt_ovf[g*GRP_CNT+k]` sets bit k of group g's leaf register (address g). A pulse on `grp_fifo_ovf[g]` sets bit GRP_CNT of that register. The bit is set from the clock edge at which the pulse is sampled.
- R2: Writing a status register keeps each bit whose written data bit is 1 and clears each bit whose written data bit is 0.
- R3: A read access never changes any status bit.
- R4: If a set pulse and a write that clears the same bit happen in the same cycle, the bit ends set.
- R5: Summary bit g (address NUM_GRP) is 1 one cycle after a leaf update exactly when both of these hold:
  - group enable bit g is 1;
  - leaf g has any counter bit set, or its FIFO bit is set while FIFO-enable bit g is 1.
- R6: The group FIFO bit latches whatever the FIFO-enable setting is. The FIFO-enable setting only gates that bit's contribution to the summary.
- R7: The link register (address NUM_GRP+3, LINK_W bits, bit i from `link_cnt_ovf[i]`) latches with no enable. Any set bit raises the interrupt.
- R8: The non-bonded register (address NUM_GRP+4) latches `nb_cnt_ovf` into bits 0..NB_CNT-1 and `nb_fifo_ovf` into bit NB_CNT.
- R9: `irq` is a register. It is 1 on the cycle after any summary bit, link bit or non-bonded bit is 1, and 0 otherwise.
- R10: After reset, every status, enable and summary register reads 0, and `irq` is 0.
- R11: The address map is as follows:
  - groups at 0..NUM_GRP-1;
  - summary at NUM_GRP (read-only, writes ignored);
  - group enable at NUM_GRP+1;
  - FIFO enable at NUM_GRP+2;
  - link at NUM_GRP+3;
  - non-bonded at NUM_GRP+4.

  Unused bits and unmapped addresses read 0.
- R12: `reg_rdata` holds the value addressed by `reg_addr` in the cycle `reg_rd` was high, one clock edge after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_cnt_ovf | input | NUM_GRP*GRP_CNT | Group counter overflow pulses, group-major |
| grp_fifo_ovf | input | NUM_GRP | Group receive-FIFO overflow pulses |
| link_cnt_ovf | input | LINK_W | Per-link counter overflow pulses |
| nb_cnt_ovf | input | NB_CNT | Non-bonded transmit counter overflow pulses |
| nb_fifo_ovf | input | 1 | Non-bonded receive-FIFO overflow pulse |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request level |

## Verification
The bench uses the default parameters:
- four groups of four counters plus one FIFO;
- an eight-bit link register;
- a four-counter non-bonded register.

With these values all nine mapped addresses exist. Both leaf widths of five bits and the full eight-bit link width are covered, so the zero upper bits of the narrower registers can be checked. The bench also reads an address beyond the map. With four groups, the summary can be driven through each case of the enable masks:
- a counter source alone;
- a FIFO source gated off, then enabled;
- a clear that empties the summary.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

  localparam int REG_W = 8;

  // next value of one sticky status bit
  function automatic logic sticky_bit(input logic cur, input logic wr_sel,
                                      input logic wd, input logic set);
    logic kept;
    kept = wr_sel ? (cur & wd) : cur;
    return kept | set;
  endfunction

  // does a group contribute to its summary bit
  function automatic logic grp_live(input logic cnt_any, input logic fifo_bit,
                                    input logic fifo_en, input logic grp_en);
    return grp_en & (cnt_any | (fifo_bit & fifo_en));
  endfunction

endpackage

// File: rtl/ovf_sticky_reg.sv
module ovf_sticky_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  import ovf_irq_pkg::*;

  logic [W-1:0] nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign nxt[b] = sticky_bit(q_o[b], wr_i, wdata_i[b], set_i[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/ovf_group_summary.sv
module ovf_group_summary #(
  parameter int NUM_GRP = 4,
  parameter int GRP_CNT = 4,
  localparam int GRP_SRC = GRP_CNT + 1
) (
  input  logic [NUM_GRP*GRP_SRC-1:0] leaf_i,
  input  logic [NUM_GRP-1:0]         grp_en_i,
  input  logic [NUM_GRP-1:0]         fifo_en_i,
  output logic [NUM_GRP-1:0]         live_o
);
  import ovf_irq_pkg::*;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_SRC-1:0] leaf;
    assign leaf      = leaf_i[g*GRP_SRC +: GRP_SRC];
    assign live_o[g] = grp_live(|leaf[GRP_CNT-1:0], leaf[GRP_CNT],
                                fifo_en_i[g], grp_en_i[g]);
  end
endmodule

// File: rtl/ovf_irq_aggregator.sv
module ovf_irq_aggregator #(
  parameter int NUM_GRP = 4,
  parameter int GRP_CNT = 4,
  parameter int LINK_W  = 8,
  parameter int NB_CNT  = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP*GRP_CNT-1:0] grp_cnt_ovf,
  input  logic [NUM_GRP-1:0]         grp_fifo_ovf,
  input  logic [LINK_W-1:0]          link_cnt_ovf,
  input  logic [NB_CNT-1:0]          nb_cnt_ovf,
  input  logic                       nb_fifo_ovf,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_wr,
  input  logic [7:0]                 reg_wdata,
  input  logic                       reg_rd,
  output logic [7:0]                 reg_rdata,
  output logic                       irq
);
  import ovf_irq_pkg::*;

  localparam int GRP_SRC  = GRP_CNT + 1;
  localparam int NB_W     = NB_CNT + 1;
  localparam int A_SUM    = NUM_GRP;
  localparam int A_GRPEN  = NUM_GRP + 1;
  localparam int A_FIFOEN = NUM_GRP + 2;
  localparam int A_LINK   = NUM_GRP + 3;
  localparam int A_NB     = NUM_GRP + 4;

  // named write events
  logic [NUM_GRP-1:0] wr_grp;
  logic               wr_grpen, wr_fifoen, wr_link, wr_nb;

  assign wr_grpen  = reg_wr && (reg_addr == ADDR_W'(A_GRPEN));
  assign wr_fifoen = reg_wr && (reg_addr == ADDR_W'(A_FIFOEN));
  assign wr_link   = reg_wr && (reg_addr == ADDR_W'(A_LINK));
  assign wr_nb     = reg_wr && (reg_addr == ADDR_W'(A_NB));

  // group leaf registers
  logic [NUM_GRP*GRP_SRC-1:0] leaf_flat;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_leaf
    assign wr_grp[g] = reg_wr && (reg_addr == ADDR_W'(g));
    ovf_sticky_reg #(.W(GRP_SRC)) u_leaf (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  ({grp_fifo_ovf[g], grp_cnt_ovf[g*GRP_CNT +: GRP_CNT]}),
      .wr_i   (wr_grp[g]),
      .wdata_i(reg_wdata[GRP_SRC-1:0]),
      .q_o    (leaf_flat[g*GRP_SRC +: GRP_SRC])
    );
  end

  // link and non-bonded status
  logic [LINK_W-1:0] link_q;
  logic [NB_W-1:0]   nb_q;

  ovf_sticky_reg #(.W(LINK_W)) u_link (
    .clk(clk), .rst_n(rst_n), .set_i(link_cnt_ovf), .wr_i(wr_link),
    .wdata_i(reg_wdata[LINK_W-1:0]), .q_o(link_q)
  );

  ovf_sticky_reg #(.W(NB_W)) u_nb (
    .clk(clk), .rst_n(rst_n), .set_i({nb_fifo_ovf, nb_cnt_ovf}), .wr_i(wr_nb),
    .wdata_i(reg_wdata[NB_W-1:0]), .q_o(nb_q)
  );

  // enable masks
  logic [NUM_GRP-1:0] grp_en_q, fifo_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_en_q  <= '0;
      fifo_en_q <= '0;
    end else begin
      if (wr_grpen)  grp_en_q  <= reg_wdata[NUM_GRP-1:0];
      if (wr_fifoen) fifo_en_q <= reg_wdata[NUM_GRP-1:0];
    end
  end

  // summary level
  logic [NUM_GRP-1:0] sum_live, sum_q;

  ovf_group_summary #(.NUM_GRP(NUM_GRP), .GRP_CNT(GRP_CNT)) u_sum (
    .leaf_i(leaf_flat), .grp_en_i(grp_en_q), .fifo_en_i(fifo_en_q), .live_o(sum_live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_live;
  end

  // interrupt level
  logic irq_next;
  assign irq_next = (|sum_q) | (|link_q) | (|nb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  // read port
  logic [REG_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (reg_addr == ADDR_W'(g)) rd_next = REG_W'(leaf_flat[g*GRP_SRC +: GRP_SRC]);
    end
    if (reg_addr == ADDR_W'(A_SUM))    rd_next = REG_W'(sum_q);
    if (reg_addr == ADDR_W'(A_GRPEN))  rd_next = REG_W'(grp_en_q);
    if (reg_addr == ADDR_W'(A_FIFOEN)) rd_next = REG_W'(fifo_en_q);
    if (reg_addr == ADDR_W'(A_LINK))   rd_next = REG_W'(link_q);
    if (reg_addr == ADDR_W'(A_NB))     rd_next = REG_W'(nb_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/ovf_irq_checker.sv
module ovf_irq_checker #(
  parameter int NUM_GRP = 4,
  parameter int LINK_W  = 8,
  parameter int NB_W    = 5,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LINK_W-1:0]  link_cnt_ovf,
  input logic [LINK_W-1:0]  link_q,
  input logic               wr_link,
  input logic [NB_W-1:0]    nb_q,
  input logic [NUM_GRP-1:0] sum_q,
  input logic [NUM_GRP-1:0] grp_en_q,
  input logic               irq,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [7:0]         reg_rdata
);
  localparam int A_NB = NUM_GRP + 4;

  // R7 / R4: a sampled link pulse always leaves its bit set
  p_link_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(link_cnt_ovf) != '0) |->
      ((link_q & $past(link_cnt_ovf)) == $past(link_cnt_ovf)));

  // R3: without a write to the link register no bit falls
  p_link_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_link) |->
      ((link_q & $past(link_q)) == $past(link_q)));

  // R5: a summary bit is set only for a group enabled in the prior cycle
  p_sum_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sum_q & ~$past(grp_en_q)) == '0));

  // R9: any pending link status raises irq on the next cycle
  p_irq_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q != '0) |=> irq);

  // R9: irq is never high without some status in the prior cycle
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq |-> ($past(link_q) != '0 || $past(nb_q) != '0 || $past(sum_q) != '0));

  // R11: unmapped addresses read zero
  p_rd_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_rd) && ($past(reg_addr) > ADDR_W'(A_NB)) |-> (reg_rdata == 8'h00));
endmodule

bind ovf_irq_aggregator ovf_irq_checker #(
  .NUM_GRP(NUM_GRP), .LINK_W(LINK_W), .NB_W(NB_CNT + 1), .ADDR_W(ADDR_W)
) u_ovf_irq_checker (
  .clk(clk), .rst_n(rst_n), .link_cnt_ovf(link_cnt_ovf), .link_q(link_q),
  .wr_link(wr_link), .nb_q(nb_q), .sum_q(sum_q), .grp_en_q(grp_en_q), .irq(irq),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_ovf_irq_aggregator.sv
module test_ovf_irq_aggregator;
  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PL = 2'd2, OP_PN = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 4'd7, 8'h00, 8'h00, 4'd10},  // R10 link starts clear
    '{OP_PL, 4'd0, 8'hA5, 8'h00, 4'd7},
    '{OP_RD, 4'd7, 8'h00, 8'hA5, 4'd7},   // R7 latched
    '{OP_RD, 4'd7, 8'h00, 8'hA5, 4'd3},   // R3 read leaves it
    '{OP_WR, 4'd7, 8'hFF, 8'h00, 4'd2},
    '{OP_RD, 4'd7, 8'h00, 8'hA5, 4'd2},   // R2 ones keep
    '{OP_WR, 4'd7, 8'hF0, 8'h00, 4'd2},
    '{OP_RD, 4'd7, 8'h00, 8'hA0, 4'd2},   // R2 zeros clear
    '{OP_PN, 4'd0, 8'h13, 8'h00, 4'd8},
    '{OP_RD, 4'd8, 8'h00, 8'h13, 4'd8},   // R8 layout
    '{OP_WR, 4'd8, 8'h0F, 8'h00, 4'd2},
    '{OP_RD, 4'd8, 8'h00, 8'h03, 4'd2},   // R2 on non-bonded
    '{OP_WR, 4'd7, 8'h00, 8'h00, 4'd2},
    '{OP_WR, 4'd8, 8'h00, 8'h00, 4'd2},
    '{OP_RD, 4'd7, 8'h00, 8'h00, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] grp_cnt_ovf = '0;
  logic [3:0]  grp_fifo_ovf = '0;
  logic [7:0]  link_cnt_ovf = '0;
  logic [3:0]  nb_cnt_ovf = '0;
  logic        nb_fifo_ovf = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_irq_aggregator i_ovf_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .grp_cnt_ovf(grp_cnt_ovf), .grp_fifo_ovf(grp_fifo_ovf),
    .link_cnt_ovf(link_cnt_ovf), .nb_cnt_ovf(nb_cnt_ovf), .nb_fifo_ovf(nb_fifo_ovf),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_link(input logic [7:0] m);
    @(negedge clk);
    link_cnt_ovf = m;
    @(negedge clk);
    link_cnt_ovf = '0;
  endtask

  task automatic pulse_nb(input logic [7:0] m);
    @(negedge clk);
    nb_cnt_ovf = m[3:0]; nb_fifo_ovf = m[4];
    @(negedge clk);
    nb_cnt_ovf = '0; nb_fifo_ovf = 1'b0;
  endtask

  task automatic pulse_grp(input logic [15:0] c, input logic [3:0] f);
    @(negedge clk);
    grp_cnt_ovf = c; grp_fifo_ovf = f;
    @(negedge clk);
    grp_cnt_ovf = '0; grp_fifo_ovf = '0;
  endtask

  initial begin
    logic [7:0] d;
    idle(3);
    check("R10 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    idle(1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: wr(VECS[i].addr, VECS[i].data);
        OP_PL: pulse_link(VECS[i].data);
        OP_PN: pulse_nb(VECS[i].data);
        default: begin
          rd(VECS[i].addr, d);
          check($sformatf("R%0d vec %0d", VECS[i].req, i), d, VECS[i].exp);
        end
      endcase
    end
    idle(2);
    check("R9 idle irq low", {7'd0, irq}, 8'h00);

    // R1 / R5: counter source, group disabled then enabled
    pulse_grp(16'h0200, 4'h0);              // group 2 counter 1
    rd(4'd2, d); check("R1 leaf2", d, 8'h02);
    idle(2);
    rd(4'd4, d); check("R5 summary masked", d, 8'h00);
    check("R9 irq masked", {7'd0, irq}, 8'h00);
    wr(4'd5, 8'h06);
    idle(2);
    rd(4'd4, d); check("R5 summary enabled", d, 8'h04);
    check("R9 irq from summary", {7'd0, irq}, 8'h01);

    // R6: FIFO bit latched but gated
    pulse_grp(16'h0000, 4'h2);              // group 1 fifo
    rd(4'd1, d); check("R6 fifo bit latched", d, 8'h10);
    idle(2);
    rd(4'd4, d); check("R6 fifo gated off", d, 8'h04);
    wr(4'd6, 8'h02);
    idle(2);
    rd(4'd4, d); check("R6 fifo enabled", d, 8'h06);

    // R2 / R5: clearing leaves
    wr(4'd2, 8'h00);
    idle(2);
    rd(4'd4, d); check("R5 after leaf2 clear", d, 8'h02);
    wr(4'd1, 8'h0F);
    idle(3);
    rd(4'd4, d); check("R5 all clear", d, 8'h00);
    check("R9 irq dropped", {7'd0, irq}, 8'h00);

    // R11: map details
    wr(4'd4, 8'hFF);
    idle(2);
    rd(4'd4, d); check("R11 summary write ignored", d, 8'h00);
    wr(4'd5, 8'hFF);
    rd(4'd5, d); check("R11 enable upper bits zero", d, 8'h0F);
    rd(4'd12, d); check("R11 unmapped address", d, 8'h00);
    wr(4'd5, 8'h00);
    wr(4'd6, 8'h00);

    // R12 / R9: timing at the ports
    idle(2);
    @(negedge clk);
    link_cnt_ovf = 8'h08;
    @(negedge clk);
    link_cnt_ovf = '0;
    check("R9 irq registered, not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R9 irq one cycle later", {7'd0, irq}, 8'h01);
    @(negedge clk);
    reg_addr = 4'd7; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 4'd0;
    @(negedge clk);
    check("R12 rdata holds read value", reg_rdata, 8'h08);

    // R4: set beats clear in the same cycle
    @(negedge clk);
    link_cnt_ovf = 8'h01; reg_addr = 4'd7; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    link_cnt_ovf = '0; reg_wr = 1'b0;
    rd(4'd7, d); check("R4 link set wins", d, 8'h01);
    @(negedge clk);
    grp_fifo_ovf = 4'h1; reg_addr = 4'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    grp_fifo_ovf = '0; reg_wr = 1'b0;
    rd(4'd0, d); check("R4 leaf set wins", d, 8'h10);

    // R10: reset with state pending
    wr(4'd5, 8'h0F);
    pulse_nb(8'h1F);
    idle(3);
    check("R9 irq pending before reset", {7'd0, irq}, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R10 irq after reset", {7'd0, irq}, 8'h00);
    rd(4'd0, d); check("R10 leaf0 after reset", d, 8'h00);
    rd(4'd5, d); check("R10 enable after reset", d, 8'h00);
    rd(4'd7, d); check("R10 link after reset", d, 8'h00);
    rd(4'd8, d); check("R10 non-bonded after reset", d, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end
endmodule